// File: doc/BRIEF.md
# Interrupt Coalescing Timer

This block cuts the interrupt rate of a network controller by merging completion events. It has two independent channels, one for transmit and one for receive. Each channel counts the single-cycle completion pulses it receives and emits one coalesced interrupt pulse when the pending count reaches a programmed threshold. A second path also emits the pulse when events have been pending for a programmed timeout. The timeout is measured in units of a short or long cycle, and each channel selects its own cycle length.

Timing comes from a bit-time strobe at the fast line rate. In slow-line mode the block qualifies only every `SLOW_DIV`-th strobe. A cycle unit is therefore `NORM_TICKS` or `LONG_TICKS` qualified strobes at either speed, and the same logic serves both speeds. A 16-bit control word carries the settings for both channels. The interrupt status and mask logic, the bus interface and the DMA engines that produce the events are outside this block.

Top module: `irq_coalescer`

## Requirements
- R1: During reset and on the first cycle after it, both interrupt outputs are low. Any pending events and timer state are discarded by reset and cause no later interrupt.
- R2: The control word's upper byte configures transmit and its lower byte configures receive. In each byte, bit 7 selects the long cycle, bits 6:4 hold the threshold and bits 3:0 hold the timeout. The channels work independently.
- R3: With threshold N, the interrupt output is high for exactly one cycle after the clock edge that samples the N-th pending event. The pending count is then empty.
- R4: A threshold field of 0 behaves exactly like a threshold of 1.
- R5: With timeout T not 0, the timer starts at the first pending event and the channel fires on timeout. The output is high after edge E1 + U*T*D + 1, where E1 samples the first event, U is the cycle length in qualified strobes and D is 1 in fast mode. Firing clears both the timer and the count.
- R6: With timeout 0, no timeout interrupt is produced. Events below the threshold stay pending and cause no interrupt.
- R7: An event sampled on the same edge as a timeout firing is not lost. It becomes the first pending event of the next interrupt, and its timer starts afresh.
- R8: The long-cycle select sets U to `LONG_TICKS` and its clear value sets U to `NORM_TICKS`, separately for each channel.
- R9: When `slow_mode` is 1, only every `SLOW_DIV`-th strobe is counted (D = `SLOW_DIV`), counting from the first pending event.
- R10: Clock cycles with `bit_tick` low do not advance the timeout.
- R11: Events on one channel never cause an interrupt pulse on the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time at the fast line rate |
| slow_mode | input | 1 | 1 selects the slow line rate (strobe divided by `SLOW_DIV`) |
| ctrl | input | 16 | Upper byte: transmit settings; lower byte: receive settings |
| tx_evt | input | 1 | Transmit completion pulse |
| rx_evt | input | 1 | Receive completion pulse |
| tx_irq | output | 1 | Coalesced transmit interrupt pulse |
| rx_irq | output | 1 | Coalesced receive interrupt pulse |

## Verification
The bench builds the block with `NORM_TICKS`=4, `LONG_TICKS`=16 and `SLOW_DIV`=3. With these values the longest timeout in any test case, a long cycle in slow mode, finishes within about fifty clocks. Every timeout latency, the divider phase in slow mode and the restart after a timeout that coincides with an event can then be checked to the exact cycle. The default sizes would need tens of thousands of clocks per case. The event counter and the control-word layout do not depend on these parameters, so the threshold and field checks hold at the full sizes too.

// File: rtl/irq_coal_pkg.sv
`timescale 1ns/1ps
package irq_coal_pkg;

    localparam int THR_W    = 3;
    localparam int TMO_W    = 4;
    localparam int CFG_W    = 1 + THR_W + TMO_W;
    localparam int CHANNELS = 2;

    // Per-channel settings: bit 7 long cycle, bits 6:4 threshold, bits 3:0 timeout
    typedef struct packed {
        logic             long_cyc;
        logic [THR_W-1:0] thr;
        logic [TMO_W-1:0] tmo;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        FIRE_NONE    = 2'd0,
        FIRE_COUNT   = 2'd1,
        FIRE_TIMEOUT = 2'd2
    } fire_e;

    // Channel 0 = receive (low byte), channel 1 = transmit (high byte)
    function automatic chan_cfg_t cfg_slice(input logic [CHANNELS*CFG_W-1:0] word,
                                            input int idx);
        return chan_cfg_t'(word[idx*CFG_W +: CFG_W]);
    endfunction

    function automatic logic [THR_W-1:0] thr_floor(input logic [THR_W-1:0] t);
        return (t == '0) ? THR_W'(1) : t;
    endfunction

endpackage

// File: rtl/coal_cycle_timer.sv
`timescale 1ns/1ps
module coal_cycle_timer
    import irq_coal_pkg::*;
#(
    parameter int NORM_TICKS = 512,
    parameter int LONG_TICKS = 8192,
    parameter int SLOW_DIV   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bit_tick,
    input  logic             slow,
    input  logic             long_cyc,
    output logic [TMO_W-1:0] units
);
    localparam int TICK_W = (LONG_TICKS > 2) ? $clog2(LONG_TICKS) : 1;
    localparam int DIV_W  = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [TICK_W-1:0] NORM_LIM = TICK_W'(NORM_TICKS - 1);
    localparam logic [TICK_W-1:0] LONG_LIM = TICK_W'(LONG_TICKS - 1);
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(SLOW_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;
    logic [TMO_W-1:0]  unit_q;
    logic [TICK_W-1:0] lim;
    logic              div_wrap;
    logic              qual_tick;
    logic              tick_wrap;

    always_comb begin
        div_wrap  = (div_q == DIV_LAST);
        qual_tick = bit_tick && (!slow || div_wrap);
        lim       = long_cyc ? LONG_LIM : NORM_LIM;
        tick_wrap = (tick_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q  <= '0;
            tick_q <= '0;
            unit_q <= '0;
        end else begin
            if (bit_tick && slow) begin
                div_q <= div_wrap ? '0 : div_q + 1'b1;
            end
            if (qual_tick) begin
                if (tick_wrap) begin
                    tick_q <= '0;
                    if (unit_q != '1) begin
                        unit_q <= unit_q + 1'b1;
                    end
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

    assign units = unit_q;

endmodule

// File: rtl/coal_channel.sv
`timescale 1ns/1ps
module coal_channel
    import irq_coal_pkg::*;
#(
    parameter int NORM_TICKS = 512,
    parameter int LONG_TICKS = 8192,
    parameter int SLOW_DIV   = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  logic      bit_tick,
    input  logic      slow,
    input  chan_cfg_t cfg,
    output logic      irq
);
    localparam int SUM_W = THR_W + 1;

    logic [THR_W-1:0] pend_q;
    logic [SUM_W-1:0] sum;
    logic [THR_W-1:0] thr_eff;
    logic [TMO_W-1:0] units;
    logic             tmr_clear;
    fire_e            cause;

    always_comb begin
        thr_eff = thr_floor(cfg.thr);
        sum     = {1'b0, pend_q} + SUM_W'(evt);
        if (sum >= {1'b0, thr_eff}) begin
            cause = FIRE_COUNT;
        end else if ((cfg.tmo != '0) && (pend_q != '0) && (units >= cfg.tmo)) begin
            cause = FIRE_TIMEOUT;
        end else begin
            cause = FIRE_NONE;
        end
        tmr_clear = (cause != FIRE_NONE) || (pend_q == '0);
    end

    coal_cycle_timer #(
        .NORM_TICKS (NORM_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .SLOW_DIV   (SLOW_DIV)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (tmr_clear),
        .bit_tick (bit_tick),
        .slow     (slow),
        .long_cyc (cfg.long_cyc),
        .units    (units)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= (cause != FIRE_NONE);
            unique case (cause)
                FIRE_COUNT:   pend_q <= '0;
                FIRE_TIMEOUT: pend_q <= THR_W'(evt);
                default:      pend_q <= sum[THR_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/irq_coalescer.sv
`timescale 1ns/1ps
module irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter int NORM_TICKS = 512,
    parameter int LONG_TICKS = 8192,
    parameter int SLOW_DIV   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_tick,
    input  logic        slow_mode,
    input  logic [15:0] ctrl,
    input  logic        tx_evt,
    input  logic        rx_evt,
    output logic        tx_irq,
    output logic        rx_irq
);
    logic [CHANNELS-1:0] evt_v;
    logic [CHANNELS-1:0] irq_v;

    assign evt_v = {tx_evt, rx_evt};

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        chan_cfg_t cfg;
        assign cfg = cfg_slice(ctrl, ch);

        coal_channel #(
            .NORM_TICKS (NORM_TICKS),
            .LONG_TICKS (LONG_TICKS),
            .SLOW_DIV   (SLOW_DIV)
        ) chan_i (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_v[ch]),
            .bit_tick (bit_tick),
            .slow     (slow_mode),
            .cfg      (cfg),
            .irq      (irq_v[ch])
        );
    end

    assign rx_irq = irq_v[0];
    assign tx_irq = irq_v[1];

endmodule

// File: rtl/irq_coalescer_chk.sv
`timescale 1ns/1ps
module irq_coalescer_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ctrl,
    input logic        tx_evt,
    input logic        rx_evt,
    input logic        tx_irq,
    input logic        rx_irq
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tx_irq && !rx_irq));

    assert_tx_no_timer_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl[11:8] == 4'd0 && !tx_evt && $stable(ctrl)) |=> !tx_irq);

    assert_rx_no_timer_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl[3:0] == 4'd0 && !rx_evt && $stable(ctrl)) |=> !rx_irq);

    assert_tx_floor_one_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl[14:12] <= 3'd1 && tx_evt) |=> tx_irq);

    assert_rx_floor_one_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl[6:4] <= 3'd1 && rx_evt) |=> rx_irq);

endmodule

bind irq_coalescer irq_coalescer_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .tx_evt (tx_evt),
    .rx_evt (rx_evt),
    .tx_irq (tx_irq),
    .rx_irq (rx_irq)
);

// File: tb/irq_coalescer_tb_top.sv
`timescale 1ns/1ps
module irq_coalescer_tb_top;

    localparam int NT  = 4;
    localparam int LT  = 16;
    localparam int SD  = 3;
    localparam int WIN = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b1;
    logic        slow_mode = 1'b0;
    logic [15:0] ctrl = 16'h1010;
    logic        tx_evt = 1'b0;
    logic        rx_evt = 1'b0;
    logic        tx_irq;
    logic        rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_coalescer #(
        .NORM_TICKS (NT),
        .LONG_TICKS (LT),
        .SLOW_DIV   (SD)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .slow_mode (slow_mode),
        .ctrl      (ctrl),
        .tx_evt    (tx_evt),
        .rx_evt    (rx_evt),
        .tx_irq    (tx_irq),
        .rx_irq    (rx_irq)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic        slow;
        logic        rx;
        logic [3:0]  nev;
        int          lat;
    } vec_t;

    // lat: clocks after the last event edge until the pulse (-1 = none)
    localparam vec_t VECS [12] = '{
        '{16'h1000, 1'b0, 1'b0, 4'd1,  0},
        '{16'h3000, 1'b0, 1'b0, 4'd3,  0},
        '{16'h0000, 1'b0, 1'b0, 4'd1,  0},
        '{16'h5000, 1'b0, 1'b0, 4'd2, -1},
        '{16'h7200, 1'b0, 1'b0, 4'd1,  9},
        '{16'hF100, 1'b0, 1'b0, 4'd2, 16},
        '{16'h7200, 1'b1, 1'b0, 4'd1, 25},
        '{16'h0010, 1'b0, 1'b1, 4'd1,  0},
        '{16'h0043, 1'b0, 1'b1, 4'd2, 12},
        '{16'h00A1, 1'b1, 1'b1, 4'd1, 49},
        '{16'h0060, 1'b0, 1'b1, 4'd5, -1},
        '{16'h00B5, 1'b0, 1'b1, 4'd3,  0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:  return "R3";
            2:     return "R4";
            3, 10: return "R6";
            4, 8:  return "R5";
            5:     return "R8";
            6, 9:  return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_evt = 1'b0;
        rx_evt = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_events(input bit on_rx, input int n,
                              output int lat, output int cnt, output int other);
        @(negedge clk);
        if (on_rx) rx_evt = 1'b1; else tx_evt = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk);
        tx_evt = 1'b0;
        rx_evt = 1'b0;
        lat = -1; cnt = 0; other = 0;
        for (int j = 0; j < WIN; j++) begin
            if ((on_rx ? rx_irq : tx_irq) == 1'b1) begin
                if (lat < 0) lat = j;
                cnt++;
            end
            if ((on_rx ? tx_irq : rx_irq) == 1'b1) other++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int lat, cnt, other, seen, lat2;

        // Reset state (R1)
        repeat (2) @(negedge clk);
        check(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 outputs in reset",
              {tx_irq, rx_irq}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 outputs after reset",
              {tx_irq, rx_irq}, 0);

        // Vector table
        for (int v = 0; v < 12; v++) begin
            ctrl      = VECS[v].ctrl;
            slow_mode = VECS[v].slow;
            bit_tick  = 1'b1;
            do_reset();
            run_events(VECS[v].rx, int'(VECS[v].nev), lat, cnt, other);
            check(lat == VECS[v].lat, vec_tag(v), lat, VECS[v].lat);
            check(cnt == ((VECS[v].lat >= 0) ? 1 : 0), "R3 single pulse", cnt,
                  (VECS[v].lat >= 0) ? 1 : 0);
            check(other == 0, "R11 other channel quiet", other, 0);
        end
        slow_mode = 1'b0;

        // R1: pending state discarded by reset
        ctrl = 16'h7171;
        do_reset();
        @(negedge clk); tx_evt = 1'b1; rx_evt = 1'b1;
        @(negedge clk); tx_evt = 1'b0; rx_evt = 1'b0;
        do_reset();
        seen = 0;
        for (int j = 0; j < 40; j++) begin
            if (tx_irq || rx_irq) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R1 pending cleared by reset", seen, 0);

        // R5/R7: event on the edge a timeout fires starts the next interrupt
        ctrl = 16'h7100;
        do_reset();
        @(negedge clk); tx_evt = 1'b1;
        @(negedge clk); tx_evt = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_irq == 1'b0, "R5 no early timeout", tx_irq, 0);
        tx_evt = 1'b1;
        @(negedge clk);
        tx_evt = 1'b0;
        check(tx_irq == 1'b1, "R5 timeout latency", tx_irq, 1);
        lat2 = -1;
        for (int j = 1; j < 40; j++) begin
            @(negedge clk);
            if (tx_irq && lat2 < 0) lat2 = j;
        end
        check(lat2 == 5, "R7 coincident event kept", lat2, 5);

        // R10: timer frozen while bit_tick is low
        ctrl = 16'h7100;
        bit_tick = 1'b0;
        do_reset();
        @(negedge clk); tx_evt = 1'b1;
        @(negedge clk); tx_evt = 1'b0;
        seen = 0;
        for (int j = 0; j < 30; j++) begin
            if (tx_irq) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R10 no advance without strobe", seen, 0);
        bit_tick = 1'b1;
        lat2 = -1;
        for (int j = 1; j < 40; j++) begin
            @(negedge clk);
            if (tx_irq && lat2 < 0) lat2 = j;
        end
        check(lat2 == 5, "R10 resumes with strobe", lat2, 5);

        // R8/R11: per-channel cycle length, both channels at once
        ctrl = 16'hF171;
        do_reset();
        @(negedge clk); tx_evt = 1'b1; rx_evt = 1'b1;
        @(negedge clk); tx_evt = 1'b0; rx_evt = 1'b0;
        lat = -1; lat2 = -1;
        for (int j = 0; j < WIN; j++) begin
            if (tx_irq && lat < 0) lat = j;
            if (rx_irq && lat2 < 0) lat2 = j;
            @(negedge clk);
        end
        check(lat == 17, "R8 transmit long cycle", lat, 17);
        check(lat2 == 5, "R11 receive independent", lat2, 5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule